// File: doc/BRIEF.md
# Keyboard Port Trap and Legacy Interrupt Control Register

This block is a single 16-bit configuration register that lets system management firmware stand in for a legacy keyboard controller. It watches the I/O bus for reads and writes to the keyboard data port (60h) and the keyboard command port (64h). Each of the four kinds of access sets its own sticky status bit. Software clears a status bit by writing 1 to it. A level system management interrupt (SMI) is raised while any status bit is set together with its enable bit.

The same register also carries three other controls. It gates the USB controller's interrupt onto the PIRQD line. It shows the live USB interrupt level as a read-only bit. It reports the state of an A20GATE pass-through sequencer, which lives outside this block: a run-enable bit goes out to the sequencer, a busy bit reads back while the sequence runs, and a sticky end-of-sequence bit can raise an SMI. The register answers at configuration offset C0h.

Top module: `kbd_trap_reg`

## Requirements
- R1: After reset the register reads 2000h, and both smi_o and pirqd_o are 0.
- R2: Each access to a keyboard port sets one status bit, and the bit reads back one clock after the access: a read of 60h sets bit 8, a write of 60h sets bit 9, a read of 64h sets bit 10, and a write of 64h sets bit 11.
- R3: Status bits 15 and 11..8 are sticky. A configuration write with 1 in a status bit clears that bit, and a 0 leaves it as it is. If a set event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R4: A one-cycle pulse on pt_done_i sets status bit 15 at the next clock.
- R5: Bit 13 is read/write and resets to 1. pirqd_o equals usb_irq_i while bit 13 is 1 and stays 0 while bit 13 is 0.
- R6: Bit 12 reads the present level of usb_irq_i in the same cycle. Writes to bit 12 have no effect.
- R7: Bit 7 (SMI on pass-through end), bit 5 (pass-through run enable), bit 4 (SMI on USB interrupt) and bits 3..0 (SMI on read 60h, write 60h, read 64h, write 64h) are read/write and reset to 0. Bit 14 always reads 0.
- R8: pt_run_o equals bit 5. Bit 6 reads 1 only while pt_busy_i is 1 and bit 5 is 1, so writing 0 to bit 5 clears bit 6 in the same cycle that bit 5 changes.
- R9: smi_o is 1 exactly when at least one of these pairs is set together: bit 8 and bit 0, bit 9 and bit 1, bit 10 and bit 2, bit 11 and bit 3, bit 15 and bit 7, or bit 12 and bit 4. smi_o follows a status change with no extra register stage.
- R10: Reads and writes to I/O addresses other than 60h and 64h change no status bit.
- R11: The register is selected only when cfg_addr_i is C0h. At any other address cfg_rdata_o reads 0 and writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_i | input | 8 | Configuration register address |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Configuration read data, combinational |
| io_addr_i | input | 16 | Observed I/O bus address |
| io_rd_i | input | 1 | Observed I/O read strobe |
| io_wr_i | input | 1 | Observed I/O write strobe |
| usb_irq_i | input | 1 | USB controller interrupt level |
| pt_busy_i | input | 1 | Pass-through sequencer busy |
| pt_done_i | input | 1 | Pass-through sequence end pulse |
| pt_run_o | output | 1 | Pass-through run enable to the sequencer |
| pirqd_o | output | 1 | USB interrupt routed to PIRQD |
| smi_o | output | 1 | System management interrupt level |

## Verification
Trap events, the end-of-sequence pulse and configuration writes pass through one register, so their effects are due one clock after the cycle that carries them. The USB mirror bit, PIRQD, the busy bit and smi_o are combinational from the register contents and the inputs, so they are due in the same cycle. The driver applies every stimulus at the falling edge, waits for one rising edge, and pushes the expected register view and outputs at the next falling edge. The monitor compares them there, while all inputs are held steady.

// File: rtl/kbd_trap_pkg.sv
package kbd_trap_pkg;
  localparam int unsigned REG_W        = 16;
  localparam int unsigned N_TRAP       = 4;
  localparam int unsigned N_STICKY     = N_TRAP + 1;

  localparam int unsigned B_PT_END     = 15;
  localparam int unsigned B_USB_ROUTE  = 13;
  localparam int unsigned B_USB_LVL    = 12;
  localparam int unsigned B_TRAP_BASE  = 8;
  localparam int unsigned B_PT_SMI_EN  = 7;
  localparam int unsigned B_PT_BUSY    = 6;
  localparam int unsigned B_PT_RUN     = 5;
  localparam int unsigned B_USB_SMI_EN = 4;
  localparam int unsigned B_TRAP_EN    = 0;

  localparam logic [REG_W-1:0] RW_MASK   = 16'h20BF;
  localparam logic [REG_W-1:0] RESET_VAL = 16'h2000;

  // trap vector order: 0 rd data port, 1 wr data port, 2 rd cmd port, 3 wr cmd port
  function automatic int unsigned sticky_pos(input int unsigned idx);
    return (idx < N_TRAP) ? (B_TRAP_BASE + idx) : B_PT_END;
  endfunction

  function automatic int unsigned sticky_en_pos(input int unsigned idx);
    return (idx < N_TRAP) ? (B_TRAP_EN + idx) : B_PT_SMI_EN;
  endfunction
endpackage

// File: rtl/kbd_trap_decode.sv
module kbd_trap_decode #(
  parameter int unsigned IO_AW     = 16,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0060,
  parameter logic [IO_AW-1:0] CMD_PORT  = 16'h0064,
  localparam int unsigned NT = kbd_trap_pkg::N_TRAP
) (
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic             io_rd_i,
  input  logic             io_wr_i,
  output logic [NT-1:0]    trap_ev_o
);
  logic hit_data;
  logic hit_cmd;

  always_comb begin
    hit_data     = (io_addr_i == DATA_PORT);
    hit_cmd      = (io_addr_i == CMD_PORT);
    trap_ev_o[0] = hit_data & io_rd_i;
    trap_ev_o[1] = hit_data & io_wr_i;
    trap_ev_o[2] = hit_cmd  & io_rd_i;
    trap_ev_o[3] = hit_cmd  & io_wr_i;
  end
endmodule

// File: rtl/kbd_trap_sticky.sv
module kbd_trap_sticky #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic upd;
    logic d;

    always_comb begin
      upd = set_i[i] | clr_i[i];
      d   = set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q_o[i] <= 1'b0;
      else if (upd) q_o[i] <= d;
    end
  end
endmodule

// File: rtl/kbd_trap_ctl.sv
module kbd_trap_ctl #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] d;

  always_comb d = wdata_i & MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= RST & MASK;
    else if (we_i) q_o <= d;
  end
endmodule

// File: rtl/kbd_trap_reg.sv
module kbd_trap_reg #(
  parameter int unsigned CFG_AW = 8,
  parameter logic [CFG_AW-1:0] REG_OFFSET = 8'hC0,
  parameter int unsigned IO_AW = 16,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0060,
  parameter logic [IO_AW-1:0] CMD_PORT  = 16'h0064
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic              cfg_wr_i,
  input  logic [15:0]       cfg_wdata_i,
  output logic [15:0]       cfg_rdata_o,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic              usb_irq_i,
  input  logic              pt_busy_i,
  input  logic              pt_done_i,
  output logic              pt_run_o,
  output logic              pirqd_o,
  output logic              smi_o
);
  import kbd_trap_pkg::*;
  localparam int unsigned NS = N_STICKY;

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             reg_hit;
  logic             wr_hit;
  logic [N_TRAP-1:0] trap_ev;
  logic [NS-1:0]    sticky_set;
  logic [NS-1:0]    sticky_clr;
  logic [NS-1:0]    sticky_q;
  logic [NS-1:0]    sticky_en;
  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] reg_view;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  always_comb begin
    reg_hit = (cfg_addr_i == REG_OFFSET);
    wr_hit  = reg_hit & cfg_wr_i;
  end

  kbd_trap_decode #(
    .IO_AW(IO_AW), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
  ) u_decode (
    .io_addr_i(io_addr_i),
    .io_rd_i  (io_rd_i),
    .io_wr_i  (io_wr_i),
    .trap_ev_o(trap_ev)
  );

  for (genvar i = 0; i < NS; i++) begin : g_map
    if (i < N_TRAP) begin : g_trap
      assign sticky_set[i] = trap_ev[i];
    end else begin : g_end
      assign sticky_set[i] = pt_done_i;
    end
    assign sticky_clr[i] = wr_hit & cfg_wdata_i[sticky_pos(i)];
    assign sticky_en[i]  = ctl_q[sticky_en_pos(i)];
  end

  kbd_trap_sticky #(.N(NS)) u_sticky (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .set_i(sticky_set),
    .clr_i(sticky_clr),
    .q_o  (sticky_q)
  );

  kbd_trap_ctl #(.W(REG_W), .MASK(RW_MASK), .RST(RESET_VAL)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we_i   (wr_hit),
    .wdata_i(cfg_wdata_i),
    .q_o    (ctl_q)
  );

  always_comb begin
    reg_view = ctl_q;
    for (int i = 0; i < NS; i++) reg_view[sticky_pos(i)] = sticky_q[i];
    reg_view[B_USB_LVL] = usb_irq_i;
    reg_view[B_PT_BUSY] = pt_busy_i & ctl_q[B_PT_RUN];
    cfg_rdata_o = reg_hit ? reg_view : '0;
    pt_run_o    = ctl_q[B_PT_RUN];
    pirqd_o     = usb_irq_i & ctl_q[B_USB_ROUTE];
    smi_o       = (|(sticky_q & sticky_en)) | (usb_irq_i & ctl_q[B_USB_SMI_EN]);
  end
endmodule

// File: rtl/kbd_trap_chk.sv
module kbd_trap_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic [3:0]  trap_ev,
  input logic [4:0]  sticky_q,
  input logic        wr_hit,
  input logic [15:0] cfg_wdata_i,
  input logic [15:0] cfg_rdata_o,
  input logic        pt_done_i,
  input logic        pt_run_o,
  input logic        usb_irq_i,
  input logic        pirqd_o,
  input logic        smi_o,
  input logic [15:0] ctl_q
);
  assert_cmd_write_trap_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_ev[3] |=> sticky_q[3]);

  assert_data_read_trap_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_ev[0] |=> sticky_q[0]);

  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sticky_q[3] && !(wr_hit && cfg_wdata_i[11])) |=> sticky_q[3]);

  assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sticky_q[1] && !trap_ev[1]) |=> !sticky_q[1]);

  assert_end_sets_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pt_done_i |=> sticky_q[4]);

  assert_route_needs_irq_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pirqd_o |-> usb_irq_i);

  assert_busy_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_rdata_o[6] |-> pt_run_o);

  assert_trap_raises_smi_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sticky_q[2] && ctl_q[2]) |-> smi_o);

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_rdata_o[14]);
endmodule

bind kbd_trap_reg kbd_trap_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .trap_ev    (trap_ev),
  .sticky_q   (sticky_q),
  .wr_hit     (wr_hit),
  .cfg_wdata_i(cfg_wdata_i),
  .cfg_rdata_o(cfg_rdata_o),
  .pt_done_i  (pt_done_i),
  .pt_run_o   (pt_run_o),
  .usb_irq_i  (usb_irq_i),
  .pirqd_o    (pirqd_o),
  .smi_o      (smi_o),
  .ctl_q      (ctl_q)
);

// File: tb/kbd_trap_reg_test.sv
module kbd_trap_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OFS = 8'hC0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_addr;
  logic        cfg_wr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic [15:0] io_addr;
  logic        io_rd, io_wr, usb_irq, pt_busy, pt_done;
  logic        pt_run, pirqd, smi;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_trap_reg uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr_i(cfg_addr), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .io_addr_i(io_addr), .io_rd_i(io_rd), .io_wr_i(io_wr),
    .usb_irq_i(usb_irq), .pt_busy_i(pt_busy), .pt_done_i(pt_done),
    .pt_run_o(pt_run), .pirqd_o(pirqd), .smi_o(smi)
  );

  typedef struct {
    string       tag;
    logic [15:0] rdata;
    logic        smi;
    logic        pirqd;
    logic        run;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference state derived from the requirements
  logic [15:0] m_stk;
  logic [15:0] m_ctl;

  function automatic exp_t predict(string tag);
    exp_t e;
    logic [15:0] v;
    v = m_stk | m_ctl;
    v[12] = usb_irq;
    v[6]  = pt_busy & m_ctl[5];
    e.tag   = tag;
    e.rdata = (cfg_addr == OFS) ? v : 16'h0000;
    e.smi   = |(m_stk[11:8] & m_ctl[3:0]) | (m_stk[15] & m_ctl[7]) | (usb_irq & m_ctl[4]);
    e.pirqd = usb_irq & m_ctl[13];
    e.run   = m_ctl[5];
    return e;
  endfunction

  task automatic expect_now(string tag);
    q.push_back(predict(tag));
    wait (q.size() == 0);
  endtask

  // one clocked cycle: inputs applied at the falling edge, due one rising edge later
  task automatic cycle(input logic [15:0] a, input logic r, input logic w,
                       input logic cw, input logic [15:0] wd, input logic dn);
    io_addr = a; io_rd = r; io_wr = w;
    cfg_wr = cw; cfg_wdata = wd; pt_done = dn;
    @(posedge clk);
    @(negedge clk);
    if (cw && cfg_addr == OFS) begin
      m_stk = m_stk & ~(wd & 16'h8F00);
      m_ctl = wd & 16'h20BF;
    end
    if (a == 16'h0060 && r) m_stk[8]  = 1'b1;
    if (a == 16'h0060 && w) m_stk[9]  = 1'b1;
    if (a == 16'h0064 && r) m_stk[10] = 1'b1;
    if (a == 16'h0064 && w) m_stk[11] = 1'b1;
    if (dn) m_stk[15] = 1'b1;
    io_rd = 1'b0; io_wr = 1'b0; cfg_wr = 1'b0; pt_done = 1'b0;
  endtask

  task automatic cfg_write(input logic [15:0] wd);
    cycle(16'h0000, 1'b0, 1'b0, 1'b1, wd, 1'b0);
  endtask

  task automatic io_access(input logic [15:0] a, input logic r, input logic w);
    cycle(a, r, w, 1'b0, 16'h0000, 1'b0);
  endtask

  // monitor: compares each expected item against the ports
  initial begin
    forever begin
      exp_t e;
      wait (q.size() > 0);
      e = q[0];
      vectors++;
      if (cfg_rdata !== e.rdata || smi !== e.smi || pirqd !== e.pirqd || pt_run !== e.run) begin
        errors++;
        $display("FAIL %s: rdata=%h smi=%b pirqd=%b run=%b expected rdata=%h smi=%b pirqd=%b run=%b",
                 e.tag, cfg_rdata, smi, pirqd, pt_run, e.rdata, e.smi, e.pirqd, e.run);
      end
      void'(q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_addr = OFS; cfg_wr = 1'b0; cfg_wdata = '0;
    io_addr = '0; io_rd = 1'b0; io_wr = 1'b0;
    usb_irq = 1'b0; pt_busy = 1'b0; pt_done = 1'b0;
    m_stk = 16'h0000; m_ctl = 16'h2000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_now("R1 reset value");

    usb_irq = 1'b1;
    expect_now("R5 R6 usb routed and mirrored");

    cfg_write(16'hFFFF);
    expect_now("R7 R9 enables set, bit14 zero, usb smi");

    cfg_write(16'h1000);
    expect_now("R6 R5 write to level bit ignored, route off");
    usb_irq = 1'b0;
    expect_now("R6 level follows input");

    io_access(16'h0060, 1'b1, 1'b0);
    expect_now("R2 read data port sets bit 8");
    io_access(16'h0060, 1'b0, 1'b1);
    io_access(16'h0064, 1'b1, 1'b0);
    io_access(16'h0064, 1'b0, 1'b1);
    expect_now("R2 all four traps set");

    cfg_write(16'h0F00);
    io_access(16'h0061, 1'b1, 1'b1);
    io_access(16'h0065, 1'b0, 1'b1);
    expect_now("R10 other ports ignored");

    io_access(16'h0060, 1'b0, 1'b1);
    io_access(16'h0064, 1'b1, 1'b0);
    cfg_write(16'h0002);
    expect_now("R9 trap with enable raises smi");
    cfg_write(16'h0001);
    expect_now("R9 enable off drops smi");
    cfg_write(16'h0005);
    expect_now("R3 zero write keeps status");
    cfg_write(16'h0404);
    expect_now("R3 one write clears status");

    cycle(16'h0064, 1'b0, 1'b1, 1'b1, 16'h0808, 1'b0);
    expect_now("R3 set wins over clear");
    cfg_write(16'h0A08);
    expect_now("R3 later clear takes effect");

    cfg_write(16'h0020);
    pt_busy = 1'b1;
    expect_now("R8 busy shown while run enabled");
    cfg_write(16'h0000);
    expect_now("R8 run cleared hides busy");
    pt_busy = 1'b0;

    cycle(16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1);
    expect_now("R4 end pulse sets bit 15");
    cfg_write(16'h0080);
    expect_now("R9 end status with enable raises smi");
    cfg_write(16'h8080);
    expect_now("R3 end status cleared");

    cfg_addr = 8'hC2;
    expect_now("R11 other address reads zero");
    cfg_write(16'hFFFF);
    cfg_addr = OFS;
    expect_now("R11 write at other address ignored");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule